// File: doc/BRIEF.md
# Segment Descriptor Translation Unit

This unit turns a 16-bit segment selector and a 32-bit offset into a 32-bit linear address. It works from an 8-byte segment descriptor that it reads from memory. The selector picks the global or the local descriptor table and gives an entry index. The unit reads the eight descriptor bytes one per cycle through a byte-read port. That port returns data in the same cycle as the address. The unit then collects the scattered base and limit fields, applies the granularity scale, and checks the entry in this order: presence, descriptor class, access type, then offset range.

A request is a one-cycle pulse on `req_i` while the unit is idle. The result (linear address, fault code, access-rights byte, attribute nibble and requested level) appears together with a one-cycle `done_o` pulse. It stays on the outputs until the next result arrives. The table base addresses are plain inputs; the unit samples them when it accepts a request.

Top module: `seg_xlat`

## Requirements
- R1: The descriptor address is the local table base when selector bit 2 is 1, or the global table base when it is 0, plus eight times the index in selector bits 15:3. Selector bits 1:0 do not affect the address and are returned on `rpl_o` with the result.
- R2: After a request the unit raises `rd_en_o` for exactly 8 consecutive cycles. In the k-th of these cycles, counting from 0, `rd_addr_o` is the descriptor address plus k. The byte on `rd_data_i` in that same cycle is taken as descriptor byte k.
- R3: The base is bytes 7, 4, 3, 2 (most significant first). The 20-bit limit is the low nibble of byte 6 above bytes 1 and 0. `acc_o` carries byte 5, and `attr_o` carries the high nibble of byte 6.
- R4: When attribute bit 3 (granularity) is 0, the limit is a byte count. When it is 1, the effective limit is the 20-bit limit shifted left by 12 with 0xFFF filled into the low bits.
- R5: Fault codes: 0 none, 1 absent, 2 system, 3 write denied, 4 read denied, 5 out of range. Access byte bit 7 = 0 gives code 1. Otherwise, bit 4 = 0 gives code 2. These two take priority over every other check.
- R6: A write (`wr_i` = 1) to a code segment (access bit 3 = 1) faults with code 3. A write to a data segment whose bit 1 = 0 also faults with code 3.
- R7: A read (`wr_i` = 0) of a code segment whose bit 1 = 0 faults with code 4. Reads of data segments are always allowed.
- R8: For code segments, and for data segments with bit 2 = 0, an offset is valid when it is at most the effective limit. Otherwise the fault is code 5.
- R9: For data segments with bit 2 = 1 (expand-down), an offset is valid only when it is strictly above the effective limit. Otherwise the fault is code 5.
- R10: With no fault, `lin_o` is the base plus the offset modulo 2^32, and `acc_o` is byte 5 with bit 0 set. With a fault, `lin_o` is 0 and `acc_o` is byte 5 unchanged.
- R11: `done_o` is a one-cycle pulse in the 10th cycle after the clock edge that accepts the request. `busy_o` is high from acceptance until `done_o` falls.
- R12: After reset, `done_o`, `busy_o` and `rd_en_o` are low, and `fault_o` and `lin_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a translation (sampled when idle) |
| sel_i | input | 16 | Segment selector |
| off_i | input | 32 | Offset inside the segment |
| wr_i | input | 1 | 1 = write access, 0 = read access |
| gtab_base_i | input | 32 | Global table base address |
| ltab_base_i | input | 32 | Local table base address |
| rd_en_o | output | 1 | Descriptor byte read strobe |
| rd_addr_o | output | 32 | Descriptor byte address |
| rd_data_i | input | 8 | Byte returned in the same cycle |
| busy_o | output | 1 | Translation in progress |
| done_o | output | 1 | Result valid pulse |
| fault_o | output | 3 | Fault code |
| lin_o | output | 32 | Linear address |
| acc_o | output | 8 | Access-rights byte as reported |
| attr_o | output | 4 | High nibble of descriptor byte 6 |
| rpl_o | output | 2 | Requested level from the selector |

## Verification
The bench goes after the offsets one below, at, and one above the effective limit, under both granularity settings.
- A comparator that is off by one, or that has the expand-down sense reversed, reports a valid offset as out of range, or the reverse.
- Each access-rights pattern of the present, class, type, direction and permission bits is tried with both reads and writes. A unit that orders the checks wrongly reports a permission fault for an absent entry.
- Bases near the top of the address space make the sum wrap, which exposes a truncated adder.
- Selectors alternate between tables and carry different requested levels. A decoder that uses the wrong selector bits then reads from the wrong address.

// File: rtl/segx_pkg.sv
package segx_pkg;
  localparam int unsigned DESC_BYTES = 8;

  // access-rights byte bit positions
  localparam int unsigned AR_P   = 7;
  localparam int unsigned AR_S   = 4;
  localparam int unsigned AR_E   = 3;
  localparam int unsigned AR_EDC = 2;
  localparam int unsigned AR_WR  = 1;
  localparam int unsigned AR_A   = 0;
  // attribute nibble (byte 6 high nibble)
  localparam int unsigned AT_G   = 3;

  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_ABSENT   = 3'd1,
    FLT_SYSTEM   = 3'd2,
    FLT_NO_WRITE = 3'd3,
    FLT_NO_READ  = 3'd4,
    FLT_LIMIT    = 3'd5
  } seg_fault_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CHECK,
    ST_DONE
  } seg_state_e;

  typedef struct packed {
    logic [31:0] base;
    logic [19:0] lim;
    logic [3:0]  attr;
    logic [7:0]  acc;
  } seg_desc_t;
endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode #(
  parameter int unsigned IDX_W = 13
) (
  input  logic [IDX_W+2:0] sel_i,
  input  logic [31:0]      gtab_base_i,
  input  logic [31:0]      ltab_base_i,
  output logic [31:0]      desc_addr_o,
  output logic [1:0]       rpl_o
);
  logic [31:0] tab_base;

  always_comb begin
    tab_base    = sel_i[2] ? ltab_base_i : gtab_base_i;
    desc_addr_o = tab_base + 32'({sel_i[IDX_W+2:3], 3'b000});
    rpl_o       = sel_i[1:0];
  end
endmodule

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch
  import segx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clear_i,
  input  logic        active_i,
  input  logic [31:0] desc_addr_i,
  input  logic [7:0]  rd_data_i,
  output logic        rd_en_o,
  output logic [31:0] rd_addr_o,
  output logic        last_o,
  output seg_desc_t   desc_o
);
  localparam int unsigned CNT_W = $clog2(DESC_BYTES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DESC_BYTES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       byte_q [DESC_BYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clear_i)  cnt_q <= '0;
    else if (active_i) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < DESC_BYTES; b++) byte_q[b] <= '0;
    end else if (active_i) begin
      for (int b = 0; b < DESC_BYTES; b++)
        if (cnt_q == CNT_W'(b)) byte_q[b] <= rd_data_i;
    end
  end

  always_comb begin
    rd_en_o     = active_i;
    rd_addr_o   = desc_addr_i + 32'(cnt_q);
    last_o      = active_i && (cnt_q == CNT_LAST);
    desc_o.base = {byte_q[7], byte_q[4], byte_q[3], byte_q[2]};
    desc_o.lim  = {byte_q[6][3:0], byte_q[1], byte_q[0]};
    desc_o.attr = byte_q[6][7:4];
    desc_o.acc  = byte_q[5];
  end

  // R2: consecutive strobes walk up by one byte
  a_r2_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o && $past(rd_en_o) && !$past(last_o)) |-> rd_addr_o == $past(rd_addr_o) + 32'd1);
endmodule

// File: rtl/seg_check.sv
module seg_check
  import segx_pkg::*;
(
  input  logic [31:0] base_i,
  input  logic [19:0] lim_i,
  input  logic        gran_i,
  input  logic [7:0]  acc_i,
  input  logic [31:0] off_i,
  input  logic        wr_i,
  output seg_fault_e  fault_o,
  output logic [31:0] lin_o,
  output logic [7:0]  acc_o
);
  logic [31:0] lim_eff;
  logic        is_code, exp_dn, in_range;

  always_comb begin
    lim_eff  = gran_i ? {lim_i, 12'hFFF} : {12'h000, lim_i};
    is_code  = acc_i[AR_E];
    exp_dn   = !is_code && acc_i[AR_EDC];
    in_range = exp_dn ? (off_i > lim_eff) : (off_i <= lim_eff);

    if (!acc_i[AR_P])                         fault_o = FLT_ABSENT;
    else if (!acc_i[AR_S])                    fault_o = FLT_SYSTEM;
    else if (wr_i && (is_code || !acc_i[AR_WR])) fault_o = FLT_NO_WRITE;
    else if (!wr_i && is_code && !acc_i[AR_WR])  fault_o = FLT_NO_READ;
    else if (!in_range)                       fault_o = FLT_LIMIT;
    else                                      fault_o = FLT_NONE;

    lin_o = (fault_o == FLT_NONE) ? base_i + off_i : '0;
    acc_o = acc_i;
    if (fault_o == FLT_NONE) acc_o[AR_A] = 1'b1;
  end
endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
  import segx_pkg::*;
#(
  parameter int unsigned IDX_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [IDX_W+2:0] sel_i,
  input  logic [31:0]      off_i,
  input  logic             wr_i,
  input  logic [31:0]      gtab_base_i,
  input  logic [31:0]      ltab_base_i,
  output logic             rd_en_o,
  output logic [31:0]      rd_addr_o,
  input  logic [7:0]       rd_data_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [2:0]       fault_o,
  output logic [31:0]      lin_o,
  output logic [7:0]       acc_o,
  output logic [3:0]       attr_o,
  output logic [1:0]       rpl_o
);
  seg_state_e  state_q;
  logic [31:0] off_q, daddr_q, daddr_d;
  logic        wr_q, last;
  logic [1:0]  rpl_d, rpl_q;
  seg_desc_t   desc;
  seg_fault_e  chk_fault;
  logic [31:0] chk_lin;
  logic [7:0]  chk_acc;

  seg_sel_decode #(.IDX_W(IDX_W)) i_dec (
    .sel_i       (sel_i),
    .gtab_base_i (gtab_base_i),
    .ltab_base_i (ltab_base_i),
    .desc_addr_o (daddr_d),
    .rpl_o       (rpl_d)
  );

  seg_desc_fetch i_fetch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (state_q == ST_IDLE),
    .active_i    (state_q == ST_FETCH),
    .desc_addr_i (daddr_q),
    .rd_data_i   (rd_data_i),
    .rd_en_o     (rd_en_o),
    .rd_addr_o   (rd_addr_o),
    .last_o      (last),
    .desc_o      (desc)
  );

  seg_check i_chk (
    .base_i  (desc.base),
    .lim_i   (desc.lim),
    .gran_i  (desc.attr[AT_G]),
    .acc_i   (desc.acc),
    .off_i   (off_q),
    .wr_i    (wr_q),
    .fault_o (chk_fault),
    .lin_o   (chk_lin),
    .acc_o   (chk_acc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      off_q   <= '0;
      wr_q    <= 1'b0;
      daddr_q <= '0;
      rpl_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          off_q   <= off_i;
          wr_q    <= wr_i;
          daddr_q <= daddr_d;
          rpl_q   <= rpl_d;
          state_q <= ST_FETCH;
        end
        ST_FETCH: if (last) state_q <= ST_CHECK;
        ST_CHECK: state_q <= ST_DONE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_o <= '0;
      lin_o   <= '0;
      acc_o   <= '0;
      attr_o  <= '0;
      rpl_o   <= '0;
    end else if (state_q == ST_CHECK) begin
      fault_o <= chk_fault;
      lin_o   <= chk_lin;
      acc_o   <= chk_acc;
      attr_o  <= desc.attr;
      rpl_o   <= rpl_q;
    end
  end

  assign done_o = (state_q == ST_DONE);
  assign busy_o = (state_q != ST_IDLE);

  // R11: result strobe lasts one cycle
  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R2: the check stage only follows a completed fetch
  a_r2_fetch_then_check: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CHECK) |-> $past(rd_en_o));
  // R10: faulted results carry no address
  a_r10_fault_no_lin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o != 3'd0) |-> lin_o == 32'd0);
  // R10: clean results report the accessed flag
  a_r10_acc_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o == 3'd0) |-> acc_o[0]);
  // R5: fault codes stay inside the defined set
  a_r5_code_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> fault_o <= 3'd5);
endmodule

// File: tb/test_seg_xlat.sv
`timescale 1ns/1ps
module test_seg_xlat;
  localparam logic [31:0] GT = 32'h0000_0040;
  localparam logic [31:0] LT = 32'h0000_0180;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [15:0] sel = '0;
  logic [31:0] off = '0;
  logic        wr = 1'b0;
  logic        rd_en, busy, done;
  logic [31:0] rd_addr, lin;
  logic [7:0]  rd_data, acc;
  logic [2:0]  fault;
  logic [3:0]  attr;
  logic [1:0]  rpl;
  logic [7:0]  mem [1024];
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  assign rd_data = mem[rd_addr[9:0]];

  seg_xlat i_seg_xlat (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .sel_i(sel), .off_i(off), .wr_i(wr),
    .gtab_base_i(GT), .ltab_base_i(LT), .rd_en_o(rd_en), .rd_addr_o(rd_addr),
    .rd_data_i(rd_data), .busy_o(busy), .done_o(done), .fault_o(fault),
    .lin_o(lin), .acc_o(acc), .attr_o(attr), .rpl_o(rpl)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] base, input logic [19:0] lim,
                          input logic [7:0] ar, input logic [3:0] at);
    mem[a[9:0]]       = lim[7:0];
    mem[a[9:0] + 10'd1] = lim[15:8];
    mem[a[9:0] + 10'd2] = base[7:0];
    mem[a[9:0] + 10'd3] = base[15:8];
    mem[a[9:0] + 10'd4] = base[23:16];
    mem[a[9:0] + 10'd5] = ar;
    mem[a[9:0] + 10'd6] = {at, lim[19:16]};
    mem[a[9:0] + 10'd7] = base[31:24];
  endtask

  task automatic run(input logic [12:0] idx, input bit tbl, input logic [1:0] rl,
                     input logic [31:0] o, input bit w, input logic [2:0] ef,
                     input logic [31:0] elin, input logic [7:0] eacc, input logic [3:0] eat,
                     input string ftag);
    logic [31:0] da;
    bit addr_ok;
    da = (tbl ? LT : GT) + {16'd0, idx, 3'd0};
    @(negedge clk);
    sel = {idx, tbl, rl}; off = o; wr = w; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    addr_ok = 1'b1;
    for (int k = 0; k < 8; k++) begin
      if (!(rd_en && rd_addr == da + 32'(k) && busy)) addr_ok = 1'b0;
      if (k < 7) @(negedge clk);
    end
    chk(addr_ok, "R1,R2 read sequence", rd_addr, da + 32'd7);
    @(negedge clk);
    chk(!rd_en && !done && busy, "R2,R11 strobe end", {30'd0, rd_en, done}, 32'd0);
    @(negedge clk);
    chk(done && busy, "R11 done timing", {30'd0, done, busy}, 32'd3);
    chk(fault == ef, ftag, {29'd0, fault}, {29'd0, ef});
    chk(lin == elin, "R10,R3 linear address", lin, elin);
    chk(acc == eacc, "R10 access byte", {24'd0, acc}, {24'd0, eacc});
    chk(attr == eat && rpl == rl, "R3,R1 attr/level", {26'd0, attr, rpl}, {26'd0, eat, rl});
    @(negedge clk);
    chk(!done && !busy, "R11 pulse width", {30'd0, done, busy}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(!done && !busy && !rd_en && fault == 3'd0 && lin == 32'd0, "R12 reset state",
        {28'd0, done, busy, rd_en, |fault}, 32'd0);
    rst_n = 1'b1;
    for (int c = 0; c < 32; c++) begin
      for (int g = 0; g < 2; g++) begin
        for (int w = 0; w < 2; w++) begin
          for (int k = 0; k < 3; k++) begin
            logic [7:0]  ar;
            logic [3:0]  at;
            logic [19:0] lm;
            logic [31:0] bs, le, o, elin;
            logic [12:0] idx;
            logic [2:0]  ef;
            logic [7:0]  eacc;
            bit tbl, code, ed, inr;
            string ft;
            ar  = {c[4], 2'b10, c[3], c[2], c[1], c[0], 1'b0};
            at  = {g[0], c[0], 1'b0, c[1]};
            lm  = 20'h00100 + 20'(c * 'h31);
            bs  = c[0] ? 32'hFFFF_F800 - 32'(c) : 32'h0012_3400 + 32'(c * 'h10101);
            idx = 13'(c + 8 * g);
            tbl = c[2] ^ g[0];
            le  = g ? {lm, 12'hFFF} : {12'd0, lm};
            o   = le + 32'(k) - 32'd1;
            code = ar[3];
            ed   = !code && ar[2];
            inr  = ed ? (o > le) : (o <= le);
            if (!ar[7])                        begin ef = 3'd1; ft = "R5 absent"; end
            else if (!ar[4])                   begin ef = 3'd2; ft = "R5 system"; end
            else if (w != 0 && (code || !ar[1])) begin ef = 3'd3; ft = "R6 write denied"; end
            else if (w == 0 && code && !ar[1])   begin ef = 3'd4; ft = "R7 read denied"; end
            else if (!inr)                     begin ef = 3'd5; ft = ed ? "R9,R4 expand-down range" : "R8,R4 range"; end
            else                               begin ef = 3'd0; ft = ed ? "R9,R4 expand-down ok" : "R8,R4 in range"; end
            elin = (ef == 3'd0) ? bs + o : 32'd0;
            eacc = (ef == 3'd0) ? (ar | 8'h01) : ar;
            put_desc((tbl ? LT : GT) + {16'd0, idx, 3'd0}, bs, lm, ar, at);
            run(idx, tbl, 2'(k + w), o, w[0], ef, elin, eacc, at, ft);
          end
        end
      end
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule